// File: doc/BRIEF.md
# Serial Register Port for a Three-Channel Imaging Front End

This block is the slave end of a three-wire serial control link: a frame-select line held low for the length of a frame, a serial clock, and a shared data line. Through it a host reads and writes eight 9-bit control registers. Index 0 holds operating mode, index 1 holds channel sequencing, indices 2 to 4 hold the red, green and blue gain codes, and indices 5 to 7 hold the red, green and blue offset codes. The stored values leave the block on a flat bus for the rest of the chip.

All three serial lines are sampled by the chip's fast system clock through synchronizers. Serial clock edges are found from the sampled values. A write frame is committed only when the frame-select line rises after exactly the right number of bits. A read frame returns the addressed register on the shared data line. The block drives that line only while read data is due, using a separate output-enable.

Bits whose value is fixed by the register definitions are forced on every write. The power-down flag is plain storage: setting it changes no other register.

Top module: `serial_reg_port`

## Requirements
- R1: After reset the registers hold index 0 = 0x078, index 1 = 0x0C8, and all other indices = 0x000. `regsFlat[i*9 +: 9]` carries register i.
- R2: A write frame has 13 bits, all sampled on rising serial clock edges while serLoad is low. The first bit is a direction flag (0 = write). The next 3 bits are the address, MSB first. The last 9 bits are the data, MSB first. The addressed register takes the data, apart from forced bits, after serLoad rises.
- R3: A frame in which any bit count other than 13 was clocked before serLoad rises changes no register.
- R4: In a read frame (direction flag 1), the output enable goes high at the first falling serial clock edge after the 4th rising edge. Register bit 8 is then on serDataOut. Each later falling edge presents the next lower bit. The output enable is low whenever serLoad is high.
- R5: In register 0, bit 6 is always stored as 1 and bits 8:7 are always stored as 0.
- R6: In register 1, bit 8 is always stored as 0.
- R7: In registers 2 to 4, bits 8:6 are always stored as 0.
- R8: Registers 5 to 7 store all 9 bits as written (sign-magnitude, bit 8 the sign).
- R9: A read frame, and serial clock pulses while serLoad is high, leave every register unchanged.
- R10: Registers change only on a committed write. Setting the power-down flag (register 0 bit 2) leaves all other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial clock from the host |
| serLoad | input | 1 | Frame select, low for the duration of a frame |
| serDataIn | input | 1 | Serial data from the host (shared line, input side) |
| serDataOut | output | 1 | Read data toward the shared line |
| serDataOe | output | 1 | Drive enable for serDataOut onto the shared line |
| regsFlat | output | 72 | All eight 9-bit registers, register i at bits i*9+8 down to i*9 |

## Verification
A wrong internal state can show up in two places. A corrupt bit counter or shift register shows on `regsFlat` about three system clocks after serLoad rises: a write lands at the wrong index, a bad-length frame is accepted, or a good frame is dropped. A wrong read-load or shift state shows on serDataOut at the next falling serial clock edge, as a misordered or stale bit that a readback compare catches within the frame. A stray enable shows on serDataOe within four system clocks of serLoad rising. Forced-bit errors show directly on the register bus after any write that tries to flip them.

// File: rtl/sri_pkg.sv
package sri_pkg;
  localparam int DATA_W     = 9;
  localparam int ADDR_W     = 3;
  localparam int REG_COUNT  = 1 << ADDR_W;
  localparam int HDR_BITS   = 1 + ADDR_W;
  localparam int FRAME_BITS = HDR_BITS + DATA_W;
  localparam int SYNC_DEPTH = 2;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
    logic              rdLoad;
    logic [ADDR_W-1:0] rdAddr;
    logic              rdShift;
    logic              outEn;
  } ctlStrobe_t;

  function automatic logic [DATA_W-1:0] regDefault(input int idx);
    case (idx)
      0:       return 9'h078;
      1:       return 9'h0C8;
      default: return 9'h000;
    endcase
  endfunction

  // bits that a write cannot change
  function automatic logic [DATA_W-1:0] fixedMask(input int idx);
    case (idx)
      0:          return 9'h1C0;
      1:          return 9'h100;
      2, 3, 4:    return 9'h1C0;
      default:    return 9'h000;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] fixedValue(input int idx);
    case (idx)
      0:       return 9'h040;
      default: return 9'h000;
    endcase
  endfunction

  function automatic logic [REG_COUNT*DATA_W-1:0] allDefaults();
    logic [REG_COUNT*DATA_W-1:0] v;
    v = '0;
    for (int i = 0; i < REG_COUNT; i++) v[i*DATA_W +: DATA_W] = regDefault(i);
    return v;
  endfunction
endpackage

// File: rtl/sri_sync.sv
module sri_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/sri_ctrl.sv
module sri_ctrl
  import sri_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkS,
  input  logic       ldS,
  input  logic       dS,
  output ctlStrobe_t strb
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BITS - 1);

  logic                  sclkD, ldD;
  logic [CNT_W-1:0]      bitCnt;
  logic [FRAME_BITS-1:0] shiftReg;
  logic                  rdPend, rdPhase, outEnQ;

  logic sclkRise, sclkFall, ldFall, ldRise, rdLoadC;

  assign sclkRise = sclkS & ~sclkD;
  assign sclkFall = ~sclkS & sclkD;
  assign ldFall   = ~ldS & ldD;
  assign ldRise   = ldS & ~ldD;
  // the header is complete one cycle after the 4th bit; rw flag sits at HDR_BITS-1
  assign rdLoadC  = rdPend & shiftReg[HDR_BITS-1] & ~ldS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkD    <= 1'b0;
      ldD      <= 1'b1;
      bitCnt   <= CNT_MAX;
      shiftReg <= '0;
      rdPend   <= 1'b0;
      rdPhase  <= 1'b0;
      outEnQ   <= 1'b0;
    end else begin
      sclkD  <= sclkS;
      ldD    <= ldS;
      rdPend <= 1'b0;
      if (ldFall) begin
        bitCnt   <= '0;
        shiftReg <= '0;
      end else if (!ldS && sclkRise) begin
        shiftReg <= {shiftReg[FRAME_BITS-2:0], dS};
        if (bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
        if (bitCnt == CNT_HDR) rdPend <= 1'b1;
      end

      if (ldS || ldFall)       rdPhase <= 1'b0;
      else if (rdLoadC)        rdPhase <= 1'b1;

      if (ldS || ldFall)             outEnQ <= 1'b0;
      else if (rdPhase && sclkFall)  outEnQ <= 1'b1;
    end
  end

  always_comb begin
    strb.wrEn    = ldRise & (bitCnt == CNT_FULL) & ~shiftReg[FRAME_BITS-1];
    strb.wrAddr  = shiftReg[DATA_W +: ADDR_W];
    strb.wrData  = shiftReg[DATA_W-1:0];
    strb.rdLoad  = rdLoadC;
    strb.rdAddr  = shiftReg[ADDR_W-1:0];
    // the first falling edge presents bit 8 as loaded; later ones advance
    strb.rdShift = outEnQ & sclkFall & ~ldS;
    strb.outEn   = outEnQ;
  end
endmodule

// File: rtl/sri_regs.sv
module sri_regs
  import sri_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  ctlStrobe_t                  strb,
  output logic [REG_COUNT*DATA_W-1:0] regsFlat,
  output logic                        sdo
);
  logic [REG_COUNT-1:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0]                outShift;

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    localparam logic [DATA_W-1:0] MASK = fixedMask(i);
    localparam logic [DATA_W-1:0] FVAL = fixedValue(i);
    localparam logic [DATA_W-1:0] RVAL = regDefault(i);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regs[i] <= RVAL;
      else if (strb.wrEn && strb.wrAddr == ADDR_W'(i))
        regs[i] <= (strb.wrData & ~MASK) | (FVAL & MASK);
    end
    assign regsFlat[i*DATA_W +: DATA_W] = regs[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              outShift <= '0;
    else if (strb.rdLoad)   outShift <= regs[strb.rdAddr];
    else if (strb.rdShift)  outShift <= {outShift[DATA_W-2:0], 1'b0};
  end

  assign sdo = outShift[DATA_W-1];
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import sri_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        serClk,
  input  logic                        serLoad,
  input  logic                        serDataIn,
  output logic                        serDataOut,
  output logic                        serDataOe,
  output logic [REG_COUNT*DATA_W-1:0] regsFlat
);
  logic [2:0] syncOut;
  ctlStrobe_t strb;

  sri_sync #(.STAGES(SYNC_DEPTH), .WIDTH(3), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({serClk, serLoad, serDataIn}),
    .dout(syncOut)
  );

  sri_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .sclkS(syncOut[2]),
    .ldS  (syncOut[1]),
    .dS   (syncOut[0]),
    .strb (strb)
  );

  sri_regs u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .regsFlat(regsFlat),
    .sdo     (serDataOut)
  );

  assign serDataOe = strb.outEn;
endmodule

// File: rtl/serial_reg_port_chk.sv
module serial_reg_port_chk
  import sri_pkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic                        serLoad,
  input logic                        serDataOe,
  input logic [REG_COUNT*DATA_W-1:0] regsFlat,
  input ctlStrobe_t                  strb
);
  p_reset_defaults_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> regsFlat == allDefaults());

  p_oe_needs_frame_r4: assert property (@(posedge clk) disable iff (!rstN)
    serDataOe |-> !$past(serLoad, SYNC_DEPTH + 1));

  p_cfg_fixed_r5: assert property (@(posedge clk) disable iff (!rstN)
    regsFlat[8:6] == 3'b001);

  p_mux_fixed_r6: assert property (@(posedge clk) disable iff (!rstN)
    regsFlat[17] == 1'b0);

  p_gain_fixed_r7: assert property (@(posedge clk) disable iff (!rstN)
    regsFlat[26:24] == 3'b000 && regsFlat[35:33] == 3'b000 && regsFlat[44:42] == 3'b000);

  p_hold_no_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEn |=> $stable(regsFlat));
endmodule

bind serial_reg_port serial_reg_port_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .serLoad  (serLoad),
  .serDataOe(serDataOe),
  .regsFlat (regsFlat),
  .strb     (strb)
);

// File: tb/sim_serial_reg_port.sv
module sim_serial_reg_port;
  localparam int HALF = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serClk = 1'b0;
  logic        serLoad = 1'b1;
  logic        serDataIn = 1'b0;
  logic        serDataOut, serDataOe;
  logic [71:0] regsFlat;

  int passCnt = 0;
  int totalCnt = 0;
  bit done = 1'b0;
  logic [8:0] expRegs [8];
  logic [8:0] rdVal;
  bit oeBad;

  always #4 clk = ~clk;

  serial_reg_port u0 (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serLoad(serLoad),
    .serDataIn(serDataIn), .serDataOut(serDataOut), .serDataOe(serDataOe),
    .regsFlat(regsFlat)
  );

  task automatic clkWait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic [8:0] act, input logic [8:0] exp);
    totalCnt++;
    if (act === exp) passCnt++;
    else $display("FAIL %s %s: actual %03h expected %03h", req, what, act, exp);
  endtask

  function automatic logic [8:0] getReg(input int i);
    return regsFlat[i*9 +: 9];
  endfunction

  // expected stored value after a write, from R5..R8
  function automatic logic [8:0] forced(input int a, input logic [8:0] d);
    case (a)
      0: return {2'b00, 1'b1, d[5:0]};
      1: return {1'b0, d[7:0]};
      2, 3, 4: return {3'b000, d[5:0]};
      default: return d;
    endcase
  endfunction

  task automatic shiftBits(input logic [15:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      serDataIn = w[i];
      clkWait(HALF);
      serClk = 1'b1;
      clkWait(HALF);
      serClk = 1'b0;
    end
  endtask

  task automatic sendFrame(input logic [15:0] w, input int n);
    serLoad = 1'b0;
    clkWait(HALF);
    shiftBits(w, n);
    clkWait(HALF);
    serLoad = 1'b1;
    clkWait(12);
  endtask

  task automatic writeReg(input int a, input logic [8:0] d);
    sendFrame(16'({1'b0, 3'(a), d}), 13);
    expRegs[a] = forced(a, d);
  endtask

  task automatic readReg(input int a, output logic [8:0] d, output bit bad);
    bad = 1'b0;
    serLoad = 1'b0;
    clkWait(HALF);
    shiftBits(16'({1'b1, 3'(a)}), 4);
    for (int k = 8; k >= 0; k--) begin
      serDataIn = 1'b0;
      clkWait(HALF);
      d[k] = serDataOut;
      if (serDataOe !== 1'b1) bad = 1'b1;
      serClk = 1'b1;
      clkWait(HALF);
      serClk = 1'b0;
    end
    clkWait(HALF);
    serLoad = 1'b1;
    clkWait(12);
    if (serDataOe !== 1'b0) bad = 1'b1;
  endtask

  task automatic checkAll(input string req, input string what);
    for (int i = 0; i < 8; i++) check(req, $sformatf("%s reg%0d", what, i), getReg(i), expRegs[i]);
  endtask

  task automatic t_reset;
    expRegs[0] = 9'h078; expRegs[1] = 9'h0C8;
    for (int i = 2; i < 8; i++) expRegs[i] = 9'h000;
    checkAll("R1", "reset default");
    check("R4", "oe idle after reset", 9'(serDataOe), 9'h0);
  endtask

  task automatic t_write;
    writeReg(2, 9'h02A);
    check("R2", "red gain write", getReg(2), 9'h02A);
    writeReg(7, 9'h1F3);
    check("R8", "blue offset negative", getReg(7), 9'h1F3);
    writeReg(6, 9'h100);
    check("R8", "green offset sign only", getReg(6), 9'h100);
    writeReg(5, 9'h0AB);
    check("R2", "red offset write", getReg(5), 9'h0AB);
  endtask

  task automatic t_reserved;
    writeReg(0, 9'h000);
    check("R5", "cfg all zero", getReg(0), 9'h040);
    writeReg(0, 9'h1FF);
    check("R5", "cfg all one", getReg(0), 9'h07F);
    writeReg(1, 9'h1FF);
    check("R6", "mux all one", getReg(1), 9'h0FF);
    writeReg(3, 9'h1FF);
    check("R7", "green gain all one", getReg(3), 9'h03F);
    writeReg(4, 9'h155);
    check("R7", "blue gain pattern", getReg(4), 9'h015);
  endtask

  task automatic t_badlen;
    logic [12:0] w;
    w = {1'b0, 3'd4, 9'h0FF};
    sendFrame(16'(w >> 1), 12);
    check("R3", "12-bit frame ignored", getReg(4), expRegs[4]);
    sendFrame(16'({w, 1'b1}), 14);
    check("R3", "14-bit frame ignored", getReg(4), expRegs[4]);
    checkAll("R3", "after bad frames");
  endtask

  task automatic t_read;
    readReg(7, rdVal, oeBad);
    check("R4", "read offset blue", rdVal, expRegs[7]);
    check("R4", "oe window", 9'(oeBad), 9'h0);
    readReg(1, rdVal, oeBad);
    check("R4", "read mux", rdVal, expRegs[1]);
    check("R4", "oe window mux", 9'(oeBad), 9'h0);
    readReg(2, rdVal, oeBad);
    check("R4", "read red gain", rdVal, expRegs[2]);
    checkAll("R9", "after reads");
  endtask

  task automatic t_idleClocks;
    for (int i = 0; i < 16; i++) begin
      serDataIn = i[0];
      clkWait(HALF);
      serClk = 1'b1;
      clkWait(HALF);
      serClk = 1'b0;
    end
    clkWait(12);
    checkAll("R9", "clocks with load high");
    check("R9", "oe stays low", 9'(serDataOe), 9'h0);
  endtask

  task automatic t_powerDown;
    writeReg(0, 9'h07C);
    check("R10", "cfg power-down set", getReg(0), 9'h07C);
    checkAll("R10", "others kept in power-down");
    readReg(5, rdVal, oeBad);
    check("R10", "readback while powered down", rdVal, expRegs[5]);
  endtask

  initial begin
    clkWait(5);
    rstN = 1'b1;
    clkWait(5);
    t_reset();
    t_write();
    t_reserved();
    t_badlen();
    t_read();
    t_idleClocks();
    t_powerDown();
    done = 1'b1;
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      totalCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", passCnt, totalCnt);
      $finish;
    end
  end
endmodule